// File: doc/BRIEF.md
# Sequential Integer Multiplier with Overflow Trap

This block multiplies two 64-bit integers over a fixed number of clock cycles. It handles one operation at a time. A function code picks the result that is returned. The choices are a 32-bit signed product sign-extended to 64 bits, the low 64 bits of a 64-bit product, or the upper 64 bits of the full unsigned 128-bit product. Two further codes repeat the 32-bit and 64-bit forms and also raise a trap flag when the signed product does not fit in the result width.

Operations enter through a valid/ready pair. The block drives `in_ready` high while it is idle. An operation transfers on a rising clock edge where `in_valid` and `in_ready` are both high. While an operation runs, `in_ready` is low and `in_valid` is ignored, so a producer simply holds its request until `in_ready` returns. The result side applies no back-pressure. `res_valid` is a single-cycle pulse, and `res_data` and `res_trap` then hold their values until the next pulse. Internally the product is formed with an unsigned radix-4 shift-add sequence that builds the full 128-bit product. Signed overflow of the 64-bit form is judged from a signed upper half, which is recovered by correcting the unsigned one.

Top module: `mul_trap_unit`

## Requirements
- R1: `in_ready` is high exactly when no operation is in flight. An operation is taken on a clock edge with `in_valid` and `in_ready` both high. `in_valid`, `in_func`, `in_a` and `in_b` have no effect while `in_ready` is low.
- R2: `res_valid` is high for exactly one cycle, 33 rising edges after the accepting edge (DW/2 + 1). `in_ready` is high again in that same cycle.
- R3: Code 0x00 returns bits 31:0 of the product of the sign-extended low 32 bits of each operand, sign-extended to 64 bits. The upper 32 bits of each operand are ignored.
- R4: Code 0x20 returns the low 64 bits of `in_a * in_b`.
- R5: Code 0x30 returns bits 127:64 of the unsigned 128-bit product of `in_a` and `in_b`.
- R6: Code 0x40 returns the same result as code 0x00. It sets `res_trap` when bits 63:31 of the 64-bit signed product of the two sign-extended low words are neither all zero nor all one.
- R7: Code 0x60 returns the same result as code 0x20. It sets `res_trap` unless the signed 128-bit product has bits 127:64 all zero with bit 63 clear, or bits 127:64 all one with bit 63 set.
- R8: `res_trap` is low for codes 0x00, 0x20 and 0x30.
- R9: Any other code is accepted with the same timing and returns zero with `res_trap` low.
- R10: After reset `res_data` is zero, `res_trap` and `res_valid` are low and `in_ready` is high. `res_data` and `res_trap` change only in a cycle where `res_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation request |
| in_ready | output | 1 | High while idle; the request transfers when both are high |
| in_func | input | 7 | Function code |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| res_valid | output | 1 | One-cycle pulse when a result is posted |
| res_data | output | 64 | Result, held until the next pulse |
| res_trap | output | 1 | Overflow trap for the checking codes, held with the result |

## Verification
The bench aims at the sign boundaries of both overflow checks. These include -2^31 times 1 against -2^31 times -1, 2^63 reached from positive operands, and -2^63 times 1 against times -1. A design that tested only the upper word, or skipped the signed correction of the unsigned upper half, would post the wrong trap on exactly these cases. All-ones operands for the unsigned upper half expose a signed core, which would return a small value instead of 0xFFFF...FFFE. Operands with garbage in their upper words catch a longword path that fails to sign-extend. The bench also holds a request high through a busy period while changing its operands, and checks that the running result is not disturbed and that the request is taken again the moment `in_ready` returns.

// File: rtl/mul_trap_pkg.sv
package mul_trap_pkg;

  localparam int FUNC_W = 7;

  typedef enum logic [FUNC_W-1:0] {
    FN_LONG      = 7'h00,
    FN_QUAD      = 7'h20,
    FN_UHIGH     = 7'h30,
    FN_LONG_CHK  = 7'h40,
    FN_QUAD_CHK  = 7'h60
  } mul_fn_e;

  typedef struct packed {
    logic known;   // a defined function code
    logic narrow;  // operate on sign-extended low halves
    logic high;    // return the upper half of the product
    logic chk;     // evaluate the overflow trap
  } fn_dec_t;

  function automatic fn_dec_t decode_fn(input logic [FUNC_W-1:0] f);
    fn_dec_t d;
    d = '0;
    case (f)
      FN_LONG:     begin d.known = 1'b1; d.narrow = 1'b1; end
      FN_QUAD:     begin d.known = 1'b1; end
      FN_UHIGH:    begin d.known = 1'b1; d.high = 1'b1; end
      FN_LONG_CHK: begin d.known = 1'b1; d.narrow = 1'b1; d.chk = 1'b1; end
      FN_QUAD_CHK: begin d.known = 1'b1; d.chk = 1'b1; end
      default:     d = '0;
    endcase
    return d;
  endfunction

  function automatic logic fn_is_narrow(input logic [FUNC_W-1:0] f);
    return (f == FN_LONG) || (f == FN_LONG_CHK);
  endfunction

endpackage

// File: rtl/mul_opnd_cond.sv
module mul_opnd_cond #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a_raw,
  input  logic [DW-1:0] b_raw,
  input  logic          narrow,
  output logic [DW-1:0] a_out,
  output logic [DW-1:0] b_out
);
  localparam int HW = DW / 2;

  logic [DW-1:0] a_sx, b_sx;

  // Narrow forms use only the low half, sign-extended to full width.
  assign a_sx  = {{(DW-HW){a_raw[HW-1]}}, a_raw[HW-1:0]};
  assign b_sx  = {{(DW-HW){b_raw[HW-1]}}, b_raw[HW-1:0]};
  assign a_out = narrow ? a_sx : a_raw;
  assign b_out = narrow ? b_sx : b_raw;
endmodule

// File: rtl/mul_r4_core.sv
module mul_r4_core #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] mcand_in,
  input  logic [DW-1:0] mplier_in,
  output logic [DW-1:0] prod_hi,
  output logic [DW-1:0] prod_lo,
  output logic          prod_done
);
  localparam int STEPS = DW / 2;
  localparam int CW    = $clog2(STEPS + 1);

  logic [DW-1:0] mcand_q;
  logic [DW+1:0] mcand3_q;
  logic [DW-1:0] acc_hi_q, acc_lo_q;
  logic [CW-1:0] steps_left_q;
  logic          done_q;
  logic [DW+1:0] pp, step_sum;

  // Partial product for the two multiplier bits now at the bottom.
  always_comb begin
    case (acc_lo_q[1:0])
      2'd0:    pp = '0;
      2'd1:    pp = {2'b00, mcand_q};
      2'd2:    pp = {1'b0, mcand_q, 1'b0};
      default: pp = mcand3_q;
    endcase
  end

  assign step_sum = {2'b00, acc_hi_q} + pp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q      <= '0;
      mcand3_q     <= '0;
      acc_hi_q     <= '0;
      acc_lo_q     <= '0;
      steps_left_q <= '0;
      done_q       <= 1'b0;
    end else if (load) begin
      mcand_q      <= mcand_in;
      mcand3_q     <= {2'b00, mcand_in} + {1'b0, mcand_in, 1'b0};
      acc_hi_q     <= '0;
      acc_lo_q     <= mplier_in;
      steps_left_q <= CW'(STEPS);
      done_q       <= 1'b0;
    end else if (steps_left_q != '0) begin
      acc_hi_q     <= step_sum[DW+1:2];
      acc_lo_q     <= {step_sum[1:0], acc_lo_q[DW-1:2]};
      steps_left_q <= steps_left_q - CW'(1);
      done_q       <= (steps_left_q == CW'(1));
    end else begin
      done_q       <= 1'b0;
    end
  end

  assign prod_hi   = acc_hi_q;
  assign prod_lo   = acc_lo_q;
  assign prod_done = done_q;
endmodule

// File: rtl/mul_result_fmt.sv
module mul_result_fmt
  import mul_trap_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0] prod_hi,
  input  logic [DW-1:0] prod_lo,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  fn_dec_t       dec,
  output logic [DW-1:0] res,
  output logic          trap
);
  localparam int HW = DW / 2;

  logic [DW-1:0] long_res, corr_a, corr_b, hi_signed;
  logic [DW-HW:0] long_top;
  logic          long_ovf, quad_ovf;

  // Narrow form: the full signed product fits in DW bits already.
  assign long_res = {{(DW-HW){prod_lo[HW-1]}}, prod_lo[HW-1:0]};
  assign long_top = prod_lo[DW-1:HW-1];
  assign long_ovf = !((&long_top) || !(|long_top));

  // Signed upper half recovered from the unsigned one.
  assign corr_a    = opa[DW-1] ? opb : '0;
  assign corr_b    = opb[DW-1] ? opa : '0;
  assign hi_signed = prod_hi - corr_a - corr_b;
  assign quad_ovf  = !(((~|hi_signed) && !prod_lo[DW-1]) ||
                       ((&hi_signed) && prod_lo[DW-1]));

  always_comb begin
    res  = '0;
    trap = 1'b0;
    if (dec.known) begin
      if (dec.high)        res = prod_hi;
      else if (dec.narrow) res = long_res;
      else                 res = prod_lo;
      trap = dec.chk && (dec.narrow ? long_ovf : quad_ovf);
    end
  end
endmodule

// File: rtl/mul_trap_unit.sv
module mul_trap_unit
  import mul_trap_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FUNC_W-1:0] in_func,
  input  logic [DW-1:0]     in_a,
  input  logic [DW-1:0]     in_b,
  output logic              res_valid,
  output logic [DW-1:0]     res_data,
  output logic              res_trap
);
  logic              busy_q;
  logic              accept;
  logic [FUNC_W-1:0] fn_q;
  logic [DW-1:0]     opa_q, opb_q;
  logic [DW-1:0]     a_c, b_c;
  logic [DW-1:0]     prod_hi, prod_lo;
  logic              prod_done;
  fn_dec_t           dec_q;
  logic [DW-1:0]     fmt_res;
  logic              fmt_trap;
  logic              res_valid_q, trap_q;
  logic [DW-1:0]     res_q;

  assign accept = in_valid && !busy_q;

  mul_opnd_cond #(.DW(DW)) u_cond (
    .a_raw  (in_a),
    .b_raw  (in_b),
    .narrow (fn_is_narrow(in_func)),
    .a_out  (a_c),
    .b_out  (b_c)
  );

  mul_r4_core #(.DW(DW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .mcand_in  (a_c),
    .mplier_in (b_c),
    .prod_hi   (prod_hi),
    .prod_lo   (prod_lo),
    .prod_done (prod_done)
  );

  assign dec_q = decode_fn(fn_q);

  mul_result_fmt #(.DW(DW)) u_fmt (
    .prod_hi (prod_hi),
    .prod_lo (prod_lo),
    .opa     (opa_q),
    .opb     (opb_q),
    .dec     (dec_q),
    .res     (fmt_res),
    .trap    (fmt_trap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      fn_q        <= '0;
      opa_q       <= '0;
      opb_q       <= '0;
      res_valid_q <= 1'b0;
      res_q       <= '0;
      trap_q      <= 1'b0;
    end else begin
      res_valid_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        fn_q   <= in_func;
        opa_q  <= a_c;
        opb_q  <= b_c;
      end
      if (prod_done) begin
        busy_q      <= 1'b0;
        res_valid_q <= 1'b1;
        res_q       <= fmt_res;
        trap_q      <= fmt_trap;
      end
    end
  end

  assign in_ready  = !busy_q;
  assign res_valid = res_valid_q;
  assign res_data  = res_q;
  assign res_trap  = trap_q;
endmodule

// File: rtl/mul_trap_unit_chk.sv
module mul_trap_unit_chk
  import mul_trap_pkg::*;
#(
  parameter int DW = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              res_valid,
  input logic [DW-1:0]     res_data,
  input logic              res_trap,
  input logic [FUNC_W-1:0] fn_q
);
  localparam int HW  = DW / 2;
  localparam int LAT = DW / 2 + 1;

  int lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    lat_cnt <= 0;
    else if (in_valid && in_ready) lat_cnt <= 1;
    else if (res_valid)            lat_cnt <= 0;
    else if (lat_cnt != 0)         lat_cnt <= lat_cnt + 1;
  end

  a_r1_closed_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  a_r2_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (lat_cnt == LAT + 1));

  a_r2_ready_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> in_ready);

  a_r10_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_data) && $stable(res_trap)));

  a_r8_trap_only_checked: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_trap) |-> (fn_q == FN_LONG_CHK || fn_q == FN_QUAD_CHK));

  a_r3_long_sign_extended: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (fn_q == FN_LONG || fn_q == FN_LONG_CHK)) |->
      ((&res_data[DW-1:HW-1]) || !(|res_data[DW-1:HW-1])));

  a_r9_unknown_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !decode_fn(fn_q).known) |-> (res_data == '0 && !res_trap));
endmodule

bind mul_trap_unit mul_trap_unit_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .res_valid (res_valid),
  .res_data  (res_data),
  .res_trap  (res_trap),
  .fn_q      (fn_q)
);

// File: tb/tb_mul_trap_unit.sv
`timescale 1ns/1ps
module tb_mul_trap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [6:0]  in_func = '0;
  logic [63:0] in_a = '0, in_b = '0;
  logic        res_valid;
  logic [63:0] res_data;
  logic        res_trap;

  int compared = 0, mismatched = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  mul_trap_unit dut (.*);

  // reference model state
  bit          m_ready = 1, m_valid = 0, m_trap = 0, p_trap;
  logic [63:0] m_res = '0, p_res;
  logic [6:0]  m_func = '0, p_func;
  int          left = 0;

  task automatic reference(input logic [6:0] f, input logic [63:0] a, b,
                           output logic [63:0] r, output bit t);
    logic signed [63:0]  sa, sb, p64;
    logic signed [127:0] wa, wb, w;
    logic [127:0]        u;
    sa = {{32{a[31]}}, a[31:0]};
    sb = {{32{b[31]}}, b[31:0]};
    p64 = sa * sb;
    wa = {{64{a[63]}}, a};
    wb = {{64{b[63]}}, b};
    w  = wa * wb;
    u  = {64'd0, a} * {64'd0, b};
    r = '0; t = 0;
    case (f)
      7'h00: r = {{32{p64[31]}}, p64[31:0]};
      7'h40: begin r = {{32{p64[31]}}, p64[31:0]};
                   t = !(p64[63:31] == '0 || p64[63:31] == '1); end
      7'h20: r = a * b;
      7'h60: begin r = w[63:0]; t = !(w[127:63] == '0 || w[127:63] == '1); end
      7'h30: r = u[127:64];
      default: begin r = '0; t = 0; end
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ready = 1; m_valid = 0; m_res = '0; m_trap = 0; left = 0;
    end else begin
      m_valid = 0;
      if (left > 0) begin
        left--;
        if (left == 0) begin
          m_valid = 1; m_res = p_res; m_trap = p_trap; m_ready = 1; m_func = p_func;
        end
      end else if (m_ready && in_valid) begin
        reference(in_func, in_a, in_b, p_res, p_trap);
        p_func = in_func; left = 33; m_ready = 0;
      end
    end
  end

  function automatic string tag_of(input logic [6:0] f);
    case (f)
      7'h00: return "R3";
      7'h20: return "R4";
      7'h30: return "R5";
      7'h40: return "R6";
      7'h60: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      check(in_ready === m_ready, "R1", "in_ready", 64'(in_ready), 64'(m_ready));
      check(res_valid === m_valid, "R2", "res_valid", 64'(res_valid), 64'(m_valid));
      if (m_valid) begin
        check(res_data === m_res, tag_of(m_func), "res_data", res_data, m_res);
        check(res_trap === m_trap,
              (m_func == 7'h40 || m_func == 7'h60) ? tag_of(m_func) : "R8",
              "res_trap", 64'(res_trap), 64'(m_trap));
      end else begin
        check(res_data === m_res && res_trap === m_trap, "R10", "held result",
              res_data, m_res);
      end
    end
  end

  task automatic issue(input logic [6:0] f, input logic [63:0] a, b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_func = f; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 0; in_func = 7'($urandom); in_a = {$urandom, $urandom}; in_b = {$urandom, $urandom};
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10: reset state
    check(in_ready === 1'b1 && res_valid === 1'b0 && res_data === '0 && res_trap === 1'b0,
          "R10", "reset state", res_data, 64'd0);
    // R3: longword, garbage in upper words ignored
    issue(7'h00, 64'hDEAD_BEEF_0000_0003, 64'h1234_5678_FFFF_FFFB);
    // R6: longword check cases
    issue(7'h40, 64'h0000_0000_0001_0000, 64'h0000_0000_0001_0000); // 2^32 -> trap
    issue(7'h40, 64'hFFFF_FFFF_8000_0000, 64'h0000_0000_0000_0001); // -2^31 -> ok
    issue(7'h40, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF); // -2^31*-1 -> trap
    issue(7'h40, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_0000_0001);
    // R4 / R5
    issue(7'h20, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);
    issue(7'h30, '1, '1);
    issue(7'h30, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0002);
    // R7: quad check cases
    issue(7'h60, '1, '1);                                            // 1
    issue(7'h60, 64'h4000_0000_0000_0000, 64'd2);                    // 2^63 trap
    issue(7'h60, 64'h8000_0000_0000_0000, 64'd1);                    // -2^63 ok
    issue(7'h60, 64'h8000_0000_0000_0000, '1);                       // trap
    issue(7'h60, 64'h0000_0001_0000_0000, 64'h0000_0000_8000_0000);  // 2^63 trap
    issue(7'h60, 64'hFFFF_FFFF_0000_0000, 64'h0000_0000_8000_0000);  // -2^63 ok
    // R9: unknown codes
    issue(7'h11, 64'd7, 64'd9);
    issue(7'h7F, '1, '1);
    // R1: request held high through busy with changing operands
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_func = 7'h20; in_a = 64'd1000; in_b = 64'd3;
    @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      in_func = (i % 2) ? 7'h30 : 7'h60; in_a = {$urandom, $urandom}; in_b = {$urandom, $urandom};
      @(negedge clk);
    end
    in_valid = 0;
    // mixed pseudo-random traffic
    for (int i = 0; i < 60; i++) begin
      logic [6:0] f;
      case (i % 6)
        0: f = 7'h00; 1: f = 7'h20; 2: f = 7'h30;
        3: f = 7'h40; 4: f = 7'h60; default: f = 7'($urandom);
      endcase
      issue(f, (i % 4 == 0) ? 64'($signed(32'($urandom))) : {$urandom, $urandom},
               (i % 3 == 0) ? 64'($signed(16'($urandom))) : {$urandom, $urandom});
    end
    repeat (40) @(negedge clk);
    finish_run();
  end
endmodule